// File: doc/BRIEF.md
# Streaming Mode-Amplitude Dot-Product Engine

This block turns one digitised record from a cavity coupler into a small set of mode amplitudes while the samples are still arriving, so the raw record never has to leave the chip. Software first loads K coefficient vectors, one per mode, through a simple write port. Each vector is stored in its own on-chip bank. A start pulse arms a record of programmable length. From then on, every accepted sample is multiplied by the coefficient at the current record position in every bank at once, and the products are summed in K parallel accumulators.

When the last sample of the record has been consumed, all K sums are copied to the output in the same cycle and a one-cycle done pulse marks them as fresh. The results stay on the output until the next record finishes. Writes to the coefficient banks are refused while a record is running, and a malformed start is dropped. This leaves the stored vectors and the running sums untouched by such mistakes.

Top module: `mode_dotprod_engine`

## Requirements
- R1: After reset, `amp_done`, `rec_busy` and `cfg_wr_err` are low and every amplitude lane of `amp_out` reads zero.
- R2: A coefficient write presented while idle with `cfg_wr_mode` below NUM_MODES stores `cfg_wr_data` at position `cfg_wr_addr` of that mode's vector, and later records use it.
- R3: A start with a legal length (1 to MAX_LEN) clears all accumulators, resets the record position to zero and raises `rec_busy` on the following cycle. A sample offered in the same cycle as that start is dropped.
- R4: The n-th accepted sample of a record (n counted from 0, only cycles with `smp_valid` high while busy count) is paired with coefficient n of every mode. Idle gaps in `smp_valid` change nothing. Records from 1 up to MAX_LEN samples are supported.
- R5: Lane k of `amp_out` (bits k*ACC_W upward, ACC_W bits wide, two's complement) holds the sum over the record of sample times coefficient for mode k. Samples and coefficients are 16-bit two's complement.
- R6: `rec_busy` falls on the clock edge that accepts the last sample. `amp_done` is high for exactly one cycle, two clock edges after that one, and `amp_out` changes in that same cycle.
- R7: Once a record has completed, samples offered before the next start are ignored. `amp_out` holds its value and `amp_done` stays low.
- R8: A coefficient write while `rec_busy` is high, or with `cfg_wr_mode` not below NUM_MODES, changes no stored coefficient and raises `cfg_wr_err` for one cycle on the following cycle.
- R9: A start with length 0 or greater than MAX_LEN is ignored: the block stays idle, later samples are not accumulated and no done pulse follows.
- R10: A legal start while a record is still running abandons that record. No done pulse is produced for it, and the new record's sums contain only its own samples.
- R11: Accumulators hold 4096 full-scale products without wrapping: 4096 samples of -32768 against coefficients of -32768 give exactly 2^42.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all logic on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Coefficient write request |
| cfg_wr_mode | input | MODE_W | Mode vector selected for the write |
| cfg_wr_addr | input | IDX_W | Position inside the vector |
| cfg_wr_data | input | COEF_W | Signed coefficient to store |
| cfg_wr_err | output | 1 | One-cycle pulse after a refused write |
| rec_start | input | 1 | Start a new record |
| rec_len | input | LEN_W | Record length, sampled with `rec_start` |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | DATA_W | Signed sample |
| rec_busy | output | 1 | Record in progress |
| amp_done | output | 1 | One-cycle pulse: new amplitudes on `amp_out` |
| amp_out | output | NUM_MODES*ACC_W | Flattened signed amplitudes, mode k in lane k |

## Verification
The bench builds the engine with three modes and a maximum record length of 4096. This makes a full-length, full-scale record affordable and so brings the accumulator headroom limit and the longest legal record within reach. With three modes the two-bit mode field can carry the value 3, so a write to a vector that does not exist can be issued and must be refused. The same build also allows a length of 4097, which must be rejected as a start. Random records with random valid gaps are checked against sums computed in the bench, together with directed cases for single-sample records, writes and starts that must be refused, an abandoned record and samples that arrive after completion.

// File: rtl/mdp_pkg.sv
package mdp_pkg;

  // Sequencer state: waiting for a start, or consuming a record.
  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } seq_state_e;

  // Accumulator width that absorbs n_terms full-scale products without wrap.
  function automatic int acc_width(int data_w, int coef_w, int n_terms);
    return data_w + coef_w + $clog2(n_terms);
  endfunction

endpackage

// File: rtl/mdp_coef_bank.sv
module mdp_coef_bank #(
  parameter int COEF_W = 16,
  parameter int DEPTH  = 512,
  parameter int ADDR_W = 9
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic signed [COEF_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic signed [COEF_W-1:0] rd_data
);

  logic signed [COEF_W-1:0] mem [DEPTH];

  // One write port for loading, one registered read port for the stream.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/mdp_seq.sv
module mdp_seq
  import mdp_pkg::*;
#(
  parameter int MAX_LEN   = 512,
  parameter int NUM_MODES = 6,
  parameter int LEN_W     = 10,
  parameter int IDX_W     = 9,
  parameter int MODE_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_start,
  input  logic [LEN_W-1:0]  rec_len,
  input  logic              smp_valid,
  input  logic              cfg_wr_en,
  input  logic [MODE_W-1:0] cfg_wr_mode,
  output logic              busy,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              clr,
  output logic              take,
  output logic              take_last,
  output logic              wr_ok,
  output logic              wr_err
);

  seq_state_e        st_q;
  logic [LEN_W-1:0]  idx_q;
  logic [LEN_W-1:0]  len_q;
  logic              len_legal;

  assign busy      = (st_q == SQ_RUN);
  assign len_legal = (rec_len != '0) && (rec_len <= LEN_W'(MAX_LEN));
  assign clr       = rec_start && len_legal;
  assign take      = busy && smp_valid && !clr;
  assign take_last = take && ((idx_q + LEN_W'(1)) == len_q);
  assign rd_idx    = idx_q[IDX_W-1:0];
  assign wr_ok     = cfg_wr_en && !busy && (int'(cfg_wr_mode) < NUM_MODES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      idx_q  <= '0;
      len_q  <= '0;
      wr_err <= 1'b0;
    end else begin
      wr_err <= cfg_wr_en && !wr_ok;
      if (clr) begin
        st_q  <= SQ_RUN;
        idx_q <= '0;
        len_q <= rec_len;
      end else if (take) begin
        idx_q <= idx_q + LEN_W'(1);
        if (take_last) begin
          st_q <= SQ_IDLE;
        end
      end
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx_q < len_q)); // R4
  AST_IDX_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_last) |=> (idx_q == $past(idx_q) + LEN_W'(1))); // R4
  AST_LAST_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    take_last |=> !busy); // R6
  AST_BUSY_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && busy) |=> wr_err); // R8
  AST_BAD_START_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_start && !len_legal && !busy) |=> !busy); // R9

endmodule

// File: rtl/mdp_mac_lane.sv
module mdp_mac_lane #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 44
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     mac_en,
  input  logic signed [DATA_W-1:0] smp,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [ACC_W-1:0]  acc
);

  localparam int PROD_W = DATA_W + COEF_W;

  function automatic logic signed [PROD_W-1:0] mul_sc(
    logic signed [DATA_W-1:0] s, logic signed [COEF_W-1:0] c);
    mul_sc = s * c;
  endfunction

  function automatic logic signed [ACC_W-1:0] mac_step(
    logic signed [ACC_W-1:0] a, logic signed [PROD_W-1:0] p);
    logic signed [ACC_W-1:0] p_ext;
    p_ext = {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
    mac_step = a + p_ext;
  endfunction

  logic signed [PROD_W-1:0] prod;
  assign prod = mul_sc(smp, coef);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (clr) begin
      acc <= '0;
    end else if (mac_en) begin
      acc <= mac_step(acc, prod);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_en && !clr && (acc[ACC_W-1] == prod[PROD_W-1]))
      |=> (acc[ACC_W-1] == $past(acc[ACC_W-1]))); // R11
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0)); // R3

endmodule

// File: rtl/mode_dotprod_engine.sv
module mode_dotprod_engine
  import mdp_pkg::*;
#(
  parameter  int NUM_MODES = 6,
  parameter  int MAX_LEN   = 512,
  parameter  int SUM_LEN   = 4096,
  parameter  int DATA_W    = 16,
  parameter  int COEF_W    = 16,
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int IDX_W     = $clog2(MAX_LEN),
  localparam int MODE_W    = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1,
  localparam int ACC_W     = acc_width(DATA_W, COEF_W, SUM_LEN)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_wr_en,
  input  logic [MODE_W-1:0]              cfg_wr_mode,
  input  logic [IDX_W-1:0]               cfg_wr_addr,
  input  logic signed [COEF_W-1:0]       cfg_wr_data,
  output logic                           cfg_wr_err,
  input  logic                           rec_start,
  input  logic [LEN_W-1:0]               rec_len,
  input  logic                           smp_valid,
  input  logic signed [DATA_W-1:0]       smp_data,
  output logic                           rec_busy,
  output logic                           amp_done,
  output logic [NUM_MODES*ACC_W-1:0]     amp_out
);

  // Events brought out between sequencer, banks and lanes.
  logic             seq_clr;
  logic             seq_take;
  logic             seq_take_last;
  logic             seq_wr_ok;
  logic [IDX_W-1:0] seq_rd_idx;

  // Stage 1: sample waits one cycle for the registered coefficient read.
  logic                     s1_vld;
  logic                     s1_last;
  logic signed [DATA_W-1:0] s1_data;
  // Stage 2: last product has landed, copy sums out next edge.
  logic                     fin_q;
  logic                     done_q;
  logic [NUM_MODES*ACC_W-1:0] amp_q;

  logic signed [COEF_W-1:0] coef_rd [NUM_MODES];
  logic signed [ACC_W-1:0]  acc_v   [NUM_MODES];

  mdp_seq #(
    .MAX_LEN   (MAX_LEN),
    .NUM_MODES (NUM_MODES),
    .LEN_W     (LEN_W),
    .IDX_W     (IDX_W),
    .MODE_W    (MODE_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .rec_start   (rec_start),
    .rec_len     (rec_len),
    .smp_valid   (smp_valid),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_mode (cfg_wr_mode),
    .busy        (rec_busy),
    .rd_idx      (seq_rd_idx),
    .clr         (seq_clr),
    .take        (seq_take),
    .take_last   (seq_take_last),
    .wr_ok       (seq_wr_ok),
    .wr_err      (cfg_wr_err)
  );

  for (genvar k = 0; k < NUM_MODES; k++) begin : g_mode
    logic bank_wr;
    assign bank_wr = seq_wr_ok && (cfg_wr_mode == MODE_W'(k));

    mdp_coef_bank #(
      .COEF_W (COEF_W),
      .DEPTH  (MAX_LEN),
      .ADDR_W (IDX_W)
    ) u_bank (
      .clk     (clk),
      .wr_en   (bank_wr),
      .wr_addr (cfg_wr_addr),
      .wr_data (cfg_wr_data),
      .rd_addr (seq_rd_idx),
      .rd_data (coef_rd[k])
    );

    mdp_mac_lane #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W),
      .ACC_W  (ACC_W)
    ) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (seq_clr),
      .mac_en (s1_vld),
      .smp    (s1_data),
      .coef   (coef_rd[k]),
      .acc    (acc_v[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_last <= 1'b0;
      s1_data <= '0;
      fin_q   <= 1'b0;
      done_q  <= 1'b0;
      amp_q   <= '0;
    end else begin
      s1_vld  <= seq_take;
      s1_last <= seq_take_last;
      s1_data <= smp_data;
      // A restart while the last product is in flight cancels the result.
      fin_q   <= s1_vld && s1_last && !seq_clr;
      done_q  <= fin_q;
      if (fin_q) begin
        for (int k = 0; k < NUM_MODES; k++) begin
          amp_q[k*ACC_W +: ACC_W] <= acc_v[k];
        end
      end
    end
  end

  assign amp_done = done_q;
  assign amp_out  = amp_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    amp_done |=> !amp_done); // R6
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s1_last && !seq_clr) |=> ##1 amp_done); // R6
  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !amp_done |-> $stable(amp_out)); // R7
  AST_IDLE_NO_MAC: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec_busy && !seq_clr) |=> !s1_vld); // R7

endmodule

// File: tb/mode_dotprod_engine_bench.sv
module mode_dotprod_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NM = 3;
  localparam int ML = 4096;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int AW = 44;
  localparam int LW = 13;
  localparam int IW = 12;
  localparam int MW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [MW-1:0] cfg_wr_mode = '0;
  logic [IW-1:0] cfg_wr_addr = '0;
  logic signed [CW-1:0] cfg_wr_data = '0;
  logic cfg_wr_err;
  logic rec_start = 1'b0;
  logic [LW-1:0] rec_len = '0;
  logic smp_valid = 1'b0;
  logic signed [DW-1:0] smp_data = '0;
  logic rec_busy;
  logic amp_done;
  logic [NM*AW-1:0] amp_out;

  mode_dotprod_engine #(
    .NUM_MODES (NM),
    .MAX_LEN   (ML),
    .SUM_LEN   (4096),
    .DATA_W    (DW),
    .COEF_W    (CW)
  ) u_mode_dotprod_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_mode (cfg_wr_mode),
    .cfg_wr_addr (cfg_wr_addr),
    .cfg_wr_data (cfg_wr_data),
    .cfg_wr_err  (cfg_wr_err),
    .rec_start   (rec_start),
    .rec_len     (rec_len),
    .smp_valid   (smp_valid),
    .smp_data    (smp_data),
    .rec_busy    (rec_busy),
    .amp_done    (amp_done),
    .amp_out     (amp_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cm [NM][ML];
  int smp [ML];
  longint held [NM];

  task automatic chk(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint lane(int m);
    return longint'($signed(amp_out[m*AW +: AW]));
  endfunction

  // Reference sum: walks the stored vectors in the bench's own model.
  function automatic longint ref_sum(int m, int len);
    longint total = 0;
    for (int i = 0; i < len; i++) begin
      total += longint'(smp[i]) * longint'(cm[m][i]);
    end
    return total;
  endfunction

  function automatic int rnd16();
    return int'($signed(16'($urandom())));
  endfunction

  // Called at a negedge, returns at a negedge.
  task automatic wr(int m, int a, int d, bit do_chk, int exp_err, string req);
    cfg_wr_en   = 1'b1;
    cfg_wr_mode = m[MW-1:0];
    cfg_wr_addr = a[IW-1:0];
    cfg_wr_data = d[CW-1:0];
    @(negedge clk);
    cfg_wr_en = 1'b0;
    if (exp_err == 0 && m < NM) cm[m][a] = int'($signed(d[CW-1:0]));
    if (do_chk) chk(req, "cfg_wr_err", longint'(cfg_wr_err), longint'(exp_err));
  endtask

  task automatic rec(int len, int gap_pct, bit junk_start, int badwr_at, bit tail_junk);
    longint exp_v [NM];
    for (int m = 0; m < NM; m++) exp_v[m] = ref_sum(m, len);
    rec_start = 1'b1;
    rec_len   = len[LW-1:0];
    if (junk_start) begin
      smp_valid = 1'b1;
      smp_data  = 16'sh7fff; // must be dropped (R3)
    end
    @(negedge clk);
    rec_start = 1'b0;
    smp_valid = 1'b0;
    chk("R3", "busy after start", longint'(rec_busy), 1);
    for (int i = 0; i < len; i++) begin
      while ($urandom_range(99, 0) < gap_pct) @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = smp[i][DW-1:0];
      if (i == badwr_at) begin
        cfg_wr_en   = 1'b1;
        cfg_wr_mode = '0;
        cfg_wr_addr = '0;
        cfg_wr_data = ~cm[0][0][CW-1:0];
      end
      @(negedge clk);
      smp_valid = 1'b0;
      if (i == badwr_at) begin
        cfg_wr_en = 1'b0;
        chk("R8", "cfg_wr_err while busy", longint'(cfg_wr_err), 1);
      end
    end
    chk("R6", "busy after last sample", longint'(rec_busy), 0);
    chk("R6", "done one edge after last", longint'(amp_done), 0);
    if (tail_junk) begin
      smp_valid = 1'b1;
      smp_data  = -16'sd1234;
    end
    @(negedge clk);
    chk("R6", "done two edges early", longint'(amp_done), 0);
    @(negedge clk);
    chk("R6", "done pulse", longint'(amp_done), 1);
    for (int m = 0; m < NM; m++) begin
      chk("R5", $sformatf("amplitude lane %0d", m), lane(m), exp_v[m]);
      held[m] = exp_v[m];
    end
    @(negedge clk);
    chk("R6", "done single cycle", longint'(amp_done), 0);
    if (tail_junk) begin
      repeat (3) @(negedge clk);
      smp_valid = 1'b0;
      chk("R7", "done after late samples", longint'(amp_done), 0);
      for (int m = 0; m < NM; m++)
        chk("R7", $sformatf("lane %0d held", m), lane(m), held[m]);
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "done after reset", longint'(amp_done), 0);
    chk("R1", "busy after reset", longint'(rec_busy), 0);
    chk("R1", "err after reset", longint'(cfg_wr_err), 0);
    for (int m = 0; m < NM; m++) chk("R1", "lane zero", lane(m), 0);

    // Preload the low part of every vector (R2).
    for (int m = 0; m < NM; m++)
      for (int a = 0; a < 256; a++) wr(m, a, rnd16(), 1'b0, 0, "R2");
    wr(1, 7, 100, 1'b1, 0, "R2");

    // Random records with random gaps (R4, R5).
    for (int t = 0; t < 12; t++) begin
      int len = $urandom_range(200, 2);
      for (int i = 0; i < len; i++) smp[i] = rnd16();
      rec(len, $urandom_range(50, 0), 1'b0, -1, 1'b0);
    end

    // Single-sample record with a freshly written coefficient (R2, R4).
    wr(2, 0, -300, 1'b1, 0, "R2");
    smp[0] = 3;
    rec(1, 0, 1'b0, -1, 1'b0);
    chk("R2", "written coefficient used", lane(2), -900);

    // Start beats a sample in the same cycle (R3), late samples ignored (R7).
    for (int i = 0; i < 40; i++) smp[i] = rnd16();
    rec(40, 20, 1'b1, -1, 1'b1);

    // Write refused while busy keeps the old coefficient (R8).
    for (int i = 0; i < 30; i++) smp[i] = rnd16();
    smp[0] = 1000;
    rec(30, 10, 1'b0, 3, 1'b0);

    // Write to a nonexistent mode is refused (R8).
    wr(3, 0, 5, 1'b1, 1, "R8");
    @(negedge clk);
    chk("R8", "err is one cycle", longint'(cfg_wr_err), 0);
    for (int i = 0; i < 20; i++) smp[i] = rnd16();
    rec(20, 0, 1'b0, -1, 1'b0);

    // Illegal starts: zero length and one past the limit (R9).
    for (int bad = 0; bad < 2; bad++) begin
      rec_start = 1'b1;
      rec_len   = (bad == 0) ? LW'(0) : LW'(ML + 1);
      @(negedge clk);
      rec_start = 1'b0;
      chk("R9", "busy after bad start", longint'(rec_busy), 0);
      smp_valid = 1'b1;
      smp_data  = 16'sd777;
      repeat (4) begin
        @(negedge clk);
        chk("R9", "no done after bad start", longint'(amp_done), 0);
      end
      smp_valid = 1'b0;
      for (int m = 0; m < NM; m++) chk("R9", "lane unchanged", lane(m), held[m]);
    end

    // Abandon a running record with a new start (R10).
    rec_start = 1'b1;
    rec_len   = LW'(8);
    @(negedge clk);
    rec_start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      smp_valid = 1'b1;
      smp_data  = 16'sh4000;
      @(negedge clk);
      chk("R10", "no done mid record", longint'(amp_done), 0);
    end
    smp_valid = 1'b0;
    for (int i = 0; i < 6; i++) smp[i] = rnd16();
    rec(6, 0, 1'b0, -1, 1'b0);
    chk("R10", "restart sums own samples", lane(0), ref_sum(0, 6));

    // Full-length, full-scale record (R4, R11).
    for (int a = 0; a < ML; a++) begin
      wr(0, a, -32768, 1'b0, 0, "R11");
      wr(1, a, 32767, 1'b0, 0, "R11");
      wr(2, a, (a % 2 == 1) ? 32767 : -32768, 1'b0, 0, "R11");
      smp[a] = -32768;
    end
    rec(ML, 0, 1'b0, -1, 1'b0);
    chk("R11", "full scale positive", lane(0), 64'sd1 <<< 42);
    chk("R11", "full scale negative", lane(1), -64'sd32768 * 64'sd32767 * 64'sd4096);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule